// File: doc/BRIEF.md
# Column Decimation Filter with Correlated Double Sampling

This block is the digital back end of one image-sensor column whose analog front end is a second-order delta-sigma modulator. Each pixel is converted twice: first at its reset level, then at its signal level. The block runs both conversions through a two-stage cascaded accumulator (a double integrator). The reset conversion is added with inverted sign, so once the signal conversion ends the second stage already holds the difference. No subtractor pass or pixel store is needed. The difference is scaled by an arithmetic right shift, clamped to 14 signed bits, and presented on the column bus with a one-cycle valid pulse.

A controller upstream pulses `reset_go` to open the reset-level window. After that window is full, the controller pulses `signal_go` to open the signal-level window. A modulator sample counts only in a cycle where `bit_valid` is high. The modulator cannot be stalled, so there is no ready signal on the bitstream input. The column bus applies no back-pressure either. `word_valid` is a single-cycle pulse, and `word` holds its value until the next pulse, so a bus arbiter may read it at any later time. A mode input picks a short window for the fast-frame 12-bit mode or a long window for the slow-frame 13-bit mode. The block latches the mode when it accepts `reset_go`.

Top module: `coldec_cds`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the block to idle, aborts any conversion in progress, and clears `word` to 0 and `word_valid` to 0.
- R2: A sample counts only in a cycle where `bit_valid` is high while a window is open. In the signal window, bit value 1 weighs +1 and bit value 0 weighs −1. In the reset window the weights are inverted (1 weighs −1, 0 weighs +1).
- R3: Let N be the window length, and let s_k and r_k be the ±1 values (1→+1, 0→−1) of the k-th counted bit of the signal and reset windows. The unscaled result is D = Σ_{k=1..N} (N+1−k)·(s_k − r_k).
- R4: With `mode`=0 each window takes 128 counted samples. With `mode`=1 each window takes 256. The mode is captured when `reset_go` is accepted, and changing `mode` later during that conversion has no effect.
- R5: `word` is the two's-complement 14-bit value floor(D / 2^S), with S=2 in mode 0 and S=3 in mode 1. It is clamped to the range −8192 to 8191.
- R6: `word_valid` is high for exactly one cycle. It is sampled high at the second rising edge after the edge that accepts the last signal-window sample. `word` carries the new result in that same cycle.
- R7: `word` keeps its value in every cycle where `word_valid` is low.
- R8: `reset_go` is accepted only when the block is idle. While the block is in a window, waiting for the signal strobe, or producing a result, the strobe is ignored.
- R9: `signal_go` is accepted only after a complete reset window and before the signal window has started. At any other time it is ignored, and when idle it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0: 128-sample windows (12-bit mode); 1: 256-sample windows (13-bit mode) |
| reset_go | input | 1 | Strobe that opens the reset-level window |
| signal_go | input | 1 | Strobe that opens the signal-level window |
| bit_in | input | 1 | Modulator output bit |
| bit_valid | input | 1 | High when `bit_in` carries a sample this cycle |
| word | output | 14 | Signed CDS result, held between pulses |
| word_valid | output | 1 | One-cycle pulse marking a new `word` |

## Verification
A result is due two rising edges after the edge that accepts the last signal sample. The first edge moves the controller into its dump state, and the second registers the scaled word. The bench drives inputs on falling edges and samples on falling edges. It therefore checks that `word_valid` is low one falling edge after the last sample, high with the expected word on the next falling edge, and low again on the one after, with the word unchanged. The strobes that must be ignored, the mid-conversion mode flips and the sample gaps are applied inside the same windows. Their effect is judged only through that final word, which the bench computes from its own record of the counted bits.

// File: rtl/coldec_pkg.sv
package coldec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RST  = 3'd1,
    PH_WAIT = 3'd2,
    PH_SIG  = 3'd3,
    PH_DONE = 3'd4
  } phase_t;

endpackage

// File: rtl/coldec_ctrl.sv
module coldec_ctrl
  import coldec_pkg::*;
#(
  parameter int LEN_FAST = 128,
  parameter int LEN_SLOW = 256,
  localparam int CNT_W = $clog2(LEN_SLOW)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   mode,
  input  logic   reset_go,
  input  logic   signal_go,
  input  logic   bit_valid,
  output phase_t ph,
  output logic   mode_q,
  output logic   clr_all,
  output logic   clr_first,
  output logic   acc_en,
  output logic   neg,
  output logic   dump
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_m1;
  logic             last;

  assign len_m1    = mode_q ? CNT_W'(LEN_SLOW - 1) : CNT_W'(LEN_FAST - 1);
  assign last      = (cnt == len_m1);
  assign clr_all   = (ph == PH_IDLE) && reset_go;
  assign clr_first = (ph == PH_WAIT) && signal_go;
  assign acc_en    = bit_valid && ((ph == PH_RST) || (ph == PH_SIG));
  assign neg       = (ph == PH_RST);
  assign dump      = (ph == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (reset_go) begin
          ph     <= PH_RST;
          cnt    <= '0;
          mode_q <= mode;
        end
        PH_RST: if (bit_valid) begin
          if (last) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_WAIT: if (signal_go) ph <= PH_SIG;
        PH_SIG: if (bit_valid) begin
          if (last) begin
            ph  <= PH_DONE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_DONE: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coldec_integ.sv
module coldec_integ #(
  parameter int ACC1_W = 10,
  parameter int ACC2_W = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_all,
  input  logic                     clr_first,
  input  logic                     acc_en,
  input  logic                     neg,
  input  logic                     bit_in,
  output logic signed [ACC2_W-1:0] acc2
);

  localparam int EXT_W = ACC2_W - ACC1_W;

  logic signed [ACC1_W-1:0] acc1;
  logic signed [ACC1_W-1:0] step;
  logic signed [ACC1_W-1:0] acc1_n;
  logic                     pos;

  // +1 when the bit agrees with the window polarity, -1 otherwise
  assign pos    = bit_in ^ neg;
  assign step   = $signed({{(ACC1_W-1){~pos}}, 1'b1});
  assign acc1_n = acc1 + step;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      acc1 <= '0;
      acc2 <= '0;
    end else if (clr_first) begin
      acc1 <= '0;
    end else if (acc_en) begin
      acc1 <= acc1_n;
      acc2 <= acc2 + $signed({{EXT_W{acc1_n[ACC1_W-1]}}, acc1_n});
    end
  end

endmodule

// File: rtl/coldec_scale.sv
module coldec_scale #(
  parameter int ACC2_W  = 19,
  parameter int OUT_W   = 14,
  parameter int SH_FAST = 2,
  parameter int SH_SLOW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_q,
  input  logic                     dump,
  input  logic signed [ACC2_W-1:0] acc2,
  output logic        [OUT_W-1:0]  word,
  output logic                     word_valid
);

  localparam logic signed [ACC2_W-1:0] MAXV = ACC2_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC2_W-1:0] MINV = -MAXV - ACC2_W'(1);

  logic signed [ACC2_W-1:0] shifted;
  logic        [OUT_W-1:0]  clamped;

  always_comb begin
    shifted = mode_q ? (acc2 >>> SH_SLOW) : (acc2 >>> SH_FAST);
    if (shifted > MAXV)      clamped = MAXV[OUT_W-1:0];
    else if (shifted < MINV) clamped = MINV[OUT_W-1:0];
    else                     clamped = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= dump;
      if (dump) word <= clamped;
    end
  end

endmodule

// File: rtl/coldec_cds.sv
module coldec_cds
  import coldec_pkg::*;
#(
  parameter int LEN_FAST = 128,
  parameter int LEN_SLOW = 256,
  parameter int SH_FAST  = 2,
  parameter int SH_SLOW  = 3,
  parameter int OUT_W    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             reset_go,
  input  logic             signal_go,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic [OUT_W-1:0] word,
  output logic             word_valid
);

  localparam int ACC1_W = $clog2(LEN_SLOW) + 2;
  localparam int ACC2_W = $clog2(LEN_SLOW * (LEN_SLOW + 1)) + 2;

  phase_t                   ph;
  logic                     mode_q;
  logic                     clr_all;
  logic                     clr_first;
  logic                     acc_en;
  logic                     neg;
  logic                     dump;
  logic signed [ACC2_W-1:0] acc2;

  coldec_ctrl #(.LEN_FAST(LEN_FAST), .LEN_SLOW(LEN_SLOW)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .reset_go(reset_go),
    .signal_go(signal_go), .bit_valid(bit_valid), .ph(ph), .mode_q(mode_q),
    .clr_all(clr_all), .clr_first(clr_first), .acc_en(acc_en), .neg(neg),
    .dump(dump)
  );

  coldec_integ #(.ACC1_W(ACC1_W), .ACC2_W(ACC2_W)) u_integ (
    .clk(clk), .rst(rst), .clr_all(clr_all), .clr_first(clr_first),
    .acc_en(acc_en), .neg(neg), .bit_in(bit_in), .acc2(acc2)
  );

  coldec_scale #(.ACC2_W(ACC2_W), .OUT_W(OUT_W), .SH_FAST(SH_FAST),
                 .SH_SLOW(SH_SLOW)) u_scale (
    .clk(clk), .rst(rst), .mode_q(mode_q), .dump(dump), .acc2(acc2),
    .word(word), .word_valid(word_valid)
  );

endmodule

// File: rtl/coldec_cds_chk.sv
module coldec_cds_chk
  import coldec_pkg::*;
#(
  parameter int OUT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_go,
  input logic             signal_go,
  input logic             bit_valid,
  input logic [OUT_W-1:0] word,
  input logic             word_valid,
  input phase_t           ph
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!word_valid && word == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  a_r6_dump_to_valid: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DONE) |=> word_valid);

  a_r7_word_held: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !$past(rst)) |-> $stable(word));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SIG && reset_go && !bit_valid) |=> (ph == PH_SIG));

  a_r9_idle_signal_ignored: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && signal_go && !reset_go) |=> (ph == PH_IDLE));

endmodule

bind coldec_cds coldec_cds_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .reset_go(reset_go), .signal_go(signal_go),
  .bit_valid(bit_valid), .word(word), .word_valid(word_valid), .ph(ph)
);

// File: tb/coldec_cds_test.sv
module coldec_cds_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic        reset_go = 1'b0;
  logic        signal_go = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_valid = 1'b0;
  logic [13:0] word;
  logic        word_valid;

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  coldec_cds uut (
    .clk(clk), .rst(rst), .mode(mode), .reset_go(reset_go),
    .signal_go(signal_go), .bit_in(bit_in), .bit_valid(bit_valid),
    .word(word), .word_valid(word_valid)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R6 watchdog: result never due, actual cycle %0d expected < 180000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int as_s14(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Feed one window of n counted samples; p = ones density /256, -1 = pseudo-random
  task automatic feed(input int n, input int p, input bit gaps, input bit inj,
                      inout int dsum);
    int acc = 0;
    int k = 1;
    logic b;
    while (k <= n) begin
      @(negedge clk);
      reset_go  = 1'b0;
      signal_go = 1'b0;
      step_lfsr();
      if (gaps && lfsr[0] && lfsr[1]) begin
        bit_valid = 1'b0;
        bit_in    = lfsr[7];
      end else begin
        bit_valid = 1'b1;
        if (p < 0) begin
          b = lfsr[5];
        end else begin
          acc = acc + p;
          if (acc >= 256) begin
            acc = acc - 256;
            b = 1'b1;
          end else begin
            b = 1'b0;
          end
        end
        bit_in = b;
        dsum = dsum + (n + 1 - k) * (b ? 1 : -1);
        if (inj && k == 10) begin
          reset_go  = 1'b1;
          signal_go = 1'b1;
          mode      = ~mode;
        end
        k = k + 1;
      end
    end
  endtask

  task automatic run_conv(input int md, input int pr, input int ps,
                          input bit gaps, input bit inj);
    int n  = md ? 256 : 128;
    int sh = md ? 3 : 2;
    int dr = 0;
    int ds = 0;
    int d;
    int e;
    string tg;
    tg = md ? "R3/R4/R5 mode1" : "R3/R4/R5 mode0";
    if (gaps) tg = {tg, " R2 gaps"};
    if (inj)  tg = {tg, " R8/R9 strobes"};
    @(negedge clk);
    mode      = md[0];
    reset_go  = 1'b1;
    bit_valid = 1'b0;
    feed(n, pr, gaps, inj, dr);
    @(negedge clk);
    bit_valid = 1'b0;
    reset_go  = inj;
    signal_go = 1'b0;
    @(negedge clk);
    reset_go  = 1'b0;
    signal_go = 1'b1;
    feed(n, ps, gaps, inj, ds);
    @(negedge clk);
    bit_valid = 1'b0;
    reset_go  = 1'b0;
    signal_go = 1'b0;
    check("R6 valid low one edge after last sample", int'(word_valid), 0);
    @(negedge clk);
    d = ds - dr;
    e = d >>> sh;
    if (e > 8191)  e = 8191;
    if (e < -8192) e = -8192;
    check("R6 valid pulse", int'(word_valid), 1);
    check(tg, as_s14(word), e);
    @(negedge clk);
    check("R6 valid single cycle", int'(word_valid), 0);
    check("R7 word held", as_s14(word), e);
  endtask

  initial begin
    int dens[6] = '{0, 64, 128, 200, 256, -1};
    int seen;

    repeat (3) @(negedge clk);
    check("R1 reset word", as_s14(word), 0);
    check("R1 reset valid", int'(word_valid), 0);
    rst = 1'b0;

    // R9: signal strobe while idle must not start anything
    @(negedge clk);
    signal_go = 1'b1;
    @(negedge clk);
    signal_go = 1'b0;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      bit_valid = 1'b1;
      bit_in    = i[0];
      @(negedge clk);
      if (word_valid) seen = seen + 1;
    end
    bit_valid = 1'b0;
    check("R9 idle signal strobe gives no result", seen, 0);
    check("R9 idle word untouched", as_s14(word), 0);

    for (int md = 0; md < 2; md++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          run_conv(md, dens[i], dens[j], ((i + j) % 2) == 1, ((i * 6 + j) % 5) == 0);
        end
      end
    end

    // R1: reset in the middle of a conversion
    @(negedge clk);
    mode     = 1'b0;
    reset_go = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      reset_go  = 1'b0;
      bit_valid = 1'b1;
      bit_in    = 1'b0;
    end
    @(negedge clk);
    bit_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-conversion reset word", as_s14(word), 0);
    check("R1 mid-conversion reset valid", int'(word_valid), 0);
    run_conv(0, 200, 64, 1'b0, 1'b0);
    run_conv(1, -1, 128, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule